// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between a processor core and a data memory that is one 32-bit word wide and addressed in bytes. On the load side it takes the whole word returned by memory, the two low address bits and an access size with a signedness flag. It returns the selected byte, halfword or word, extended to 32 bits with either the sign bit or zeros.

On the store side it takes the source register value, the same address bits and size, and a write request. It returns write data with the low byte or low halfword of the register copied into every lane. It also returns a 4-bit byte-enable that picks the lanes memory should update.

Lanes are numbered big-endian: the byte at the lowest address of a word occupies the most significant bits. Accesses that break the alignment rule for their size raise a misalignment flag. While that flag is high the block suppresses both the load result and the byte-enables. The block is purely combinational, so results appear in the same cycle the inputs are presented.

Top module: `lsa_aligner`

## Requirements
- R1: Size code `size_i` is 0 for byte, 1 for halfword, 2 for word; code 3 is handled exactly like code 2 (word).
- R2: A byte load at offset `addr_i` = k selects memory bits [31-8k : 24-8k], so offset 0 takes bits 31:24 and offset 3 takes bits 7:0.
- R3: A halfword load at offset 0 selects bits 31:16 and at offset 2 selects bits 15:0.
- R4: With `unsigned_i` = 0, byte and halfword loads copy the top bit of the selected value into all upper bits of `ld_data_o`.
- R5: With `unsigned_i` = 1, byte and halfword loads fill all upper bits of `ld_data_o` with zeros.
- R6: A word load at offset 0 returns the memory word unchanged, whatever the value of `unsigned_i`.
- R7: `misalign_o` is 1 for a halfword access with `addr_i[0]` = 1 or a word access with `addr_i` not 0, and 0 otherwise; byte accesses are never misaligned.
- R8: While `misalign_o` is 1, `ld_data_o` is 0 and `st_be_o` is 0.
- R9: `st_data_o` holds four copies of `st_src_i[7:0]` for bytes, two copies of `st_src_i[15:0]` for halfwords and `st_src_i` itself for words, regardless of address or alignment.
- R10: For an aligned write, `st_be_o` bit 3 stands for offset 0 and bit 0 for offset 3: byte gives 4'b1000 shifted right by the offset, halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2, word gives 4'b1111.
- R11: With `wr_i` = 0, `st_be_o` is 0 for every size and address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 2 | Byte offset of the access within the word |
| size_i | input | 2 | Access size code (0 byte, 1 halfword, 2 or 3 word) |
| unsigned_i | input | 1 | 1 selects zero extension for sub-word loads |
| wr_i | input | 1 | Store request; gates the byte-enables |
| mem_word_i | input | 32 | Word read from memory for a load |
| st_src_i | input | 32 | Register value to be stored |
| ld_data_o | output | 32 | Extended load result |
| st_data_o | output | 32 | Lane-replicated write data |
| st_be_o | output | 4 | Byte-enables, bit 3 = lowest address |
| misalign_o | output | 1 | Access breaks the alignment rule for its size |

## Verification
The bench sweeps every offset, every size code, both signedness settings and both write settings against memory and register patterns. The patterns put distinct values in each lane and set or clear the top bit of each lane, so a swapped lane order (little-endian selection) or a sign taken from the wrong bit shows up as a wrong value. Halfwords at odd offsets and words at nonzero offsets are checked for a raised flag with zeroed data and enables; a design that ignored alignment would enable bytes across a lane boundary. Size code 3 and loads with the unsigned flag set are checked against plain word behaviour, which catches an aligner that treats the spare code as a byte or that masks word loads.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // Map the spare size code onto a whole-word access.
  function automatic size_e norm_size(input size_e s);
    return (s == SZ_WIDE) ? SZ_WORD : s;
  endfunction

  function automatic logic [WORD_W-1:0] ext_lane(input logic [LANE_W-1:0] v,
                                                 input logic zero_fill);
    logic fill;
    fill = zero_fill ? 1'b0 : v[LANE_W-1];
    return {{(WORD_W-LANE_W){fill}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] ext_pair(input logic [2*LANE_W-1:0] v,
                                                 input logic zero_fill);
    logic fill;
    fill = zero_fill ? 1'b0 : v[2*LANE_W-1];
    return {{(WORD_W-2*LANE_W){fill}}, v};
  endfunction

endpackage

// File: rtl/lsa_misalign_det.sv
module lsa_misalign_det
  import lsa_pkg::*;
#(
  parameter int unsigned OFS_BITS = OFS_W
) (
  input  logic [OFS_BITS-1:0] addr_i,
  input  size_e               size_i,
  output logic                misalign_o
);

  size_e eff_size;

  always_comb begin
    eff_size = norm_size(size_i);
    unique case (eff_size)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_i[0];
      default: misalign_o = (addr_i != '0);
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE) begin
      p_byte_aligned_r7: assert (!misalign_o);
    end
  end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned LW = LANE_W,
  localparam int unsigned NL = DW / LW,
  localparam int unsigned NP = NL / 2,
  localparam int unsigned OW = $clog2(NL)
) (
  input  logic [DW-1:0] word_i,
  input  logic [OW-1:0] addr_i,
  input  size_e         size_i,
  input  logic          zero_fill_i,
  input  logic          kill_i,
  output logic [DW-1:0] data_o
);

  logic [LW-1:0]   lane_v [NL];
  logic [2*LW-1:0] pair_v [NP];
  logic [LW-1:0]   sel_lane;
  logic [2*LW-1:0] sel_pair;
  size_e           eff_size;

  // Big-endian: lane index 0 is the most significant byte of the word.
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lane_v[i] = word_i[DW-1-i*LW -: LW];
  end
  for (genvar j = 0; j < NP; j++) begin : g_pair
    assign pair_v[j] = word_i[DW-1-j*2*LW -: 2*LW];
  end

  always_comb begin
    sel_lane = lane_v[addr_i];
    sel_pair = pair_v[addr_i[OW-1:1]];
    eff_size = norm_size(size_i);
    if (kill_i) begin
      data_o = '0;
    end else begin
      unique case (eff_size)
        SZ_BYTE: data_o = ext_lane(sel_lane, zero_fill_i);
        SZ_HALF: data_o = ext_pair(sel_pair, zero_fill_i);
        default: data_o = word_i;
      endcase
    end
  end

  always_comb begin
    if (!kill_i && eff_size == SZ_BYTE && zero_fill_i) begin
      p_byte_zero_r5: assert (data_o[DW-1:LW] == '0);
    end
    if (!kill_i && eff_size == SZ_HALF && !zero_fill_i) begin
      p_half_sign_r4: assert (data_o[DW-1:2*LW] == {(DW-2*LW){data_o[2*LW-1]}});
    end
    if (!kill_i && eff_size == SZ_WORD) begin
      p_word_pass_r6: assert (data_o == word_i);
    end
  end

endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned LW = LANE_W,
  localparam int unsigned NL = DW / LW,
  localparam int unsigned OW = $clog2(NL)
) (
  input  logic [DW-1:0] src_i,
  input  logic [OW-1:0] addr_i,
  input  size_e         size_i,
  input  logic          wr_i,
  input  logic          kill_i,
  output logic [DW-1:0] data_o,
  output logic [NL-1:0] be_o
);

  size_e eff_size;
  logic  live;

  always_comb begin
    eff_size = norm_size(size_i);
    live     = wr_i && !kill_i;
  end

  // Lane i (big-endian index) drives enable bit NL-1-i.
  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int unsigned PHYS = NL - 1 - i;
    always_comb begin
      unique case (eff_size)
        SZ_BYTE: data_o[PHYS*LW +: LW] = src_i[LW-1:0];
        SZ_HALF: data_o[PHYS*LW +: LW] = src_i[(PHYS%2)*LW +: LW];
        default: data_o[PHYS*LW +: LW] = src_i[PHYS*LW +: LW];
      endcase
      unique case (eff_size)
        SZ_BYTE: be_o[PHYS] = live && (addr_i == OW'(i));
        SZ_HALF: be_o[PHYS] = live && (addr_i[OW-1:1] == (OW-1)'(i/2));
        default: be_o[PHYS] = live;
      endcase
    end
  end

  always_comb begin
    if (!wr_i) begin
      p_no_write_r11: assert (be_o == '0);
    end
    if (eff_size == SZ_BYTE) begin
      p_byte_onehot_r10: assert ($onehot0(be_o));
    end
    if (live && eff_size == SZ_HALF) begin
      p_half_pair_r10: assert ($countones(be_o) == 2);
    end
  end

endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
(
  input  logic [1:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic        unsigned_i,
  input  logic        wr_i,
  input  logic [31:0] mem_word_i,
  input  logic [31:0] st_src_i,
  output logic [31:0] ld_data_o,
  output logic [31:0] st_data_o,
  output logic [3:0]  st_be_o,
  output logic        misalign_o
);

  size_e size_w;
  logic  mis_w;

  assign size_w = size_e'(size_i);

  lsa_misalign_det #(.OFS_BITS(OFS_W)) u_mis (
    .addr_i     (addr_i),
    .size_i     (size_w),
    .misalign_o (mis_w)
  );

  lsa_load_extract #(.DW(WORD_W), .LW(LANE_W)) u_ld (
    .word_i      (mem_word_i),
    .addr_i      (addr_i),
    .size_i      (size_w),
    .zero_fill_i (unsigned_i),
    .kill_i      (mis_w),
    .data_o      (ld_data_o)
  );

  lsa_store_lanes #(.DW(WORD_W), .LW(LANE_W)) u_st (
    .src_i  (st_src_i),
    .addr_i (addr_i),
    .size_i (size_w),
    .wr_i   (wr_i),
    .kill_i (mis_w),
    .data_o (st_data_o),
    .be_o   (st_be_o)
  );

  assign misalign_o = mis_w;

  always_comb begin
    if (mis_w) begin
      p_mis_quiet_r8: assert (ld_data_o == '0 && st_be_o == '0);
    end
  end

endmodule

// File: tb/lsa_aligner_tb.sv
module lsa_aligner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        unsigned_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] mem_word_i = '0;
  logic [31:0] st_src_i = '0;
  logic [31:0] ld_data_o;
  logic [31:0] st_data_o;
  logic [3:0]  st_be_o;
  logic        misalign_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_aligner u_dut (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .unsigned_i (unsigned_i),
    .wr_i       (wr_i),
    .mem_word_i (mem_word_i),
    .st_src_i   (st_src_i),
    .ld_data_o  (ld_data_o),
    .st_data_o  (st_data_o),
    .st_be_o    (st_be_o),
    .misalign_o (misalign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d size=%0d uns=%0d wr=%0d act=%h exp=%h",
               req, addr_i, size_i, unsigned_i, wr_i, act, exp);
    end
  endtask

  // Expected load value, derived arithmetically from shifts.
  function automatic logic [31:0] exp_load(input logic [31:0] w, input int off,
                                           input int sz, input bit uns, input bit mis);
    logic [31:0] v;
    if (mis) return 32'h0;
    if (sz == 0) begin
      v = (w >> (8 * (3 - off))) & 32'hFF;
      if (!uns && v >= 32'h80) v = v + 32'hFFFF_FF00;
    end else if (sz == 1) begin
      v = (w >> (16 * (1 - off / 2))) & 32'hFFFF;
      if (!uns && v >= 32'h8000) v = v + 32'hFFFF_0000;
    end else begin
      v = w;
    end
    return v;
  endfunction

  initial begin
    logic [31:0] words [6];
    logic [31:0] srcs  [6];
    words[0] = 32'h1122_3344; words[1] = 32'h8192_A3B4; words[2] = 32'hFFFF_FFFF;
    words[3] = 32'h7F80_017E; words[4] = 32'h0000_0000; words[5] = 32'h80FF_7F00;
    srcs[0]  = 32'hDEAD_BEEF; srcs[1]  = 32'h0102_0304; srcs[2]  = 32'hFFFF_0080;
    srcs[3]  = 32'h5A5A_A5C3; srcs[4]  = 32'h0000_0000; srcs[5]  = 32'h1234_8765;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    for (int p = 0; p < 6; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int s = 0; s < 4; s++) begin
          for (int u = 0; u < 2; u++) begin
            for (int w = 0; w < 2; w++) begin
              int eff;
              bit mis;
              logic [31:0] ed;
              logic [3:0]  eb;
              @(posedge clk);
              addr_i = a[1:0]; size_i = s[1:0]; unsigned_i = u[0]; wr_i = w[0];
              mem_word_i = words[p]; st_src_i = srcs[(p + a) % 6];
              #2;
              eff = (s == 3) ? 2 : s;           // R1: code 3 acts as word
              mis = (eff == 1 && (a % 2) == 1) || (eff == 2 && a != 0);
              chk("R7 misalign", {31'b0, misalign_o}, {31'b0, mis});
              if (mis) begin
                chk("R8 load zero", ld_data_o, 32'h0);
                chk("R8 be zero", {28'b0, st_be_o}, 32'h0);
              end else if (eff == 0) begin
                chk(u ? "R2 R5 byte unsigned" : "R2 R4 byte signed", ld_data_o,
                    exp_load(words[p], a, 0, u[0], 1'b0));
              end else if (eff == 1) begin
                chk(u ? "R3 R5 half unsigned" : "R3 R4 half signed", ld_data_o,
                    exp_load(words[p], a, 1, u[0], 1'b0));
              end else begin
                chk(s == 3 ? "R1 R6 code3 word" : "R6 word", ld_data_o, words[p]);
              end
              if (eff == 0) ed = {4{st_src_i[7:0]}};
              else if (eff == 1) ed = {2{st_src_i[15:0]}};
              else ed = st_src_i;
              chk("R9 store data", st_data_o, ed);
              if (w == 0 || mis) eb = 4'b0000;
              else if (eff == 0) eb = 4'b1000 >> a;
              else if (eff == 1) eb = (a < 2) ? 4'b1100 : 4'b0011;
              else eb = 4'b1111;
              chk(w == 0 ? "R11 no write" : "R10 byte enable", {28'b0, st_be_o}, {28'b0, eb});
            end
          end
        end
      end
    end

    // Directed corners: sign bit exactly at lane top, big-endian lane pick.
    @(posedge clk);
    addr_i = 2'd0; size_i = 2'd0; unsigned_i = 1'b0; wr_i = 1'b1;
    mem_word_i = 32'h80_00_00_7F; st_src_i = 32'h0000_00AB;
    #2;
    chk("R2 R4 offset0 top lane", ld_data_o, 32'hFFFF_FF80);
    chk("R10 offset0 bit3", {28'b0, st_be_o}, 32'h8);
    addr_i = 2'd3;
    #2;
    chk("R2 offset3 low lane", ld_data_o, 32'h0000_007F);
    chk("R10 offset3 bit0", {28'b0, st_be_o}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule